// File: doc/BRIEF.md
# Hybrid Ratio-Search and Fixed-Fraction MPPT Controller

This is a digital controller for a small photovoltaic harvester. It sets the operating point as a fraction of the panel's open-circuit voltage. The fraction is applied through a tap code on an external resistor ladder. Each session starts with the panel disconnected from the converter while a hold capacitor captures the open-circuit voltage.

After that window, the controller climbs the ladder one tap at a time. An external power meter says whether the new point gives more power than the point before. The controller keeps stepping the same way while power grows and turns around when it falls. The second turn-around of a session ends the search, and the better of the two taps around the peak is kept.

From then on the controller stays in a fixed-fraction mode that holds that tap. Each tick of a slow external timer opens a fresh sampling window so the hold capacitor tracks the open-circuit voltage. The tap itself does not change.

Measurement results arrive on a valid/ready channel. `meas_ready` is high only while the controller waits for a result in the search phase. A source that raises `meas_valid` must hold it, together with `meas_gt`, until a cycle in which `meas_ready` is also high. A result is consumed only on that cycle, so holding `meas_valid` through sampling or fixed-fraction time has no effect. All other pins are plain levels or single-cycle pulses.

Top module: `mppt_hybrid_ctrl`

## Requirements
- R1: While reset is asserted, and until the first sampling window ends, the outputs are: `main_open`=1, `oc_point`=1, `track_mode`=0, `ladder_code`=0 and `meas_ready`=0.
- R2: A sampling window with length L = `sample_len` keeps `main_open` high for L+2 cycles. `sh_close` is high only for the middle L cycles, so one guard cycle sits at each end. A length of 0 acts as 1, and `sh_close` is never high unless `main_open` is high.
- R3: Tap code n selects (95 - 5n)% of the open-circuit voltage, so code 0 is 95% and code 7 is 60%. When the session window ends, `oc_point` falls, the search starts at code 0 and `meas_ready` rises.
- R4: A result is taken only in a cycle where `meas_valid` and `meas_ready` are both high. While `meas_ready` is low, `meas_valid` is ignored, and a result held through that time is taken on the first ready cycle.
- R5: The first search direction is toward higher codes. When `meas_gt`=1 the direction is kept, and when it is 0 the direction reverses. Each accepted result that does not end the search moves the code by exactly one.
- R6: A step that would leave the range 0..7 is turned back. The code moves one step inward instead, and this counts as a reversal.
- R7: The second reversal in a session ends the search. The kept code is the current code when `meas_gt`=1, and otherwise the code measured just before it.
- R8: In fixed-fraction mode `track_mode`=1 and `ladder_code` holds the kept code. `meas_ready` is 0, and `main_open` stays low between sampling windows.
- R9: A `slow_tick` in fixed-fraction mode starts a sampling window on the next cycle. The controller then returns to fixed-fraction mode with the same code.
- R10: A `slow_tick` during the search, the session window or a resampling window is ignored.
- R11: A `restart` in any state begins a new session on the next cycle. This means a sampling window, `oc_point`=1, code 0 and the search direction reset.
- R12: Outside an accepted result or a restart, `ladder_code` never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Pulse: begin a new search session |
| sample_len | input | LEN_W | Sampling window length in cycles (0 acts as 1) |
| meas_valid | input | 1 | Measurement result valid |
| meas_gt | input | 1 | 1: power at present tap exceeds power at previous point |
| meas_ready | output | 1 | Controller can take a measurement result |
| slow_tick | input | 1 | One-cycle pulse from the slow resampling timer |
| ladder_code | output | CODE_W | Ladder tap code, fraction = 95% - 5% x code |
| oc_point | output | 1 | Session open-circuit sampling in progress |
| sh_close | output | 1 | Close the sample/hold switch |
| main_open | output | 1 | Disconnect the panel from the converter |
| track_mode | output | 1 | 0: search phase, 1: fixed-fraction phase |

## Verification
Every result is registered once. A code step shows on `ladder_code` in the cycle after the accepting edge, and the switch to fixed-fraction mode shows in that same cycle. `main_open` rises in the cycle after an accepted `slow_tick` or `restart`, and `sh_close` follows one cycle later. The bench updates a behavioural model on each rising edge from the inputs that the design also sees. It compares every output on the falling edge, so each expected value is checked in exactly the cycle it is due. The kept tap after each search is also checked against the known peak of the bench's power curve.

// File: rtl/mppt_pkg.sv
package mppt_pkg;

  typedef enum logic [1:0] {
    ST_OCV_SAMPLE = 2'd0,
    ST_SEARCH     = 2'd1,
    ST_TRACK      = 2'd2,
    ST_RESAMPLE   = 2'd3
  } ctrl_state_e;

  localparam logic DIR_UP_CODE = 1'b1;

endpackage

// File: rtl/mppt_window_timer.sv
module mppt_window_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             hold_sw,
  output logic             done
);
  localparam int CNT_W = LEN_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_len;
  logic [CNT_W-1:0] last_cnt;

  // Zero length behaves as one; the window adds a guard cycle on each side.
  assign eff_len  = (len == '0) ? CNT_W'(1) : {1'b0, len};
  assign last_cnt = eff_len + CNT_W'(1);
  assign done     = busy && (cnt == last_cnt);
  assign hold_sw  = busy && (cnt != '0) && !done;

  // The reset state is an active window: every session opens with sampling.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/mppt_po_search.sv
module mppt_po_search
  import mppt_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              step,
  input  logic              gt,
  output logic [CODE_W-1:0] code,
  output logic              lock,
  output logic [CODE_W-1:0] lock_code
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  logic              dir_q;
  logic              rev_seen_q;
  logic [CODE_W-1:0] prev_q;

  logic              dir_pref;
  logic              bounce;
  logic              dir_nxt;
  logic              reversal;
  logic [CODE_W-1:0] target;

  always_comb begin
    dir_pref = gt ? dir_q : ~dir_q;
    bounce   = dir_pref ? (code == CODE_MAX) : (code == '0);
    dir_nxt  = bounce ? ~dir_pref : dir_pref;
    target   = dir_nxt ? (code + CODE_W'(1)) : (code - CODE_W'(1));
    reversal = (dir_nxt != dir_q);
  end

  assign lock      = step && reversal && rev_seen_q;
  assign lock_code = gt ? code : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code       <= '0;
      dir_q      <= DIR_UP_CODE;
      rev_seen_q <= 1'b0;
      prev_q     <= '0;
    end else if (init) begin
      code       <= '0;
      dir_q      <= DIR_UP_CODE;
      rev_seen_q <= 1'b0;
      prev_q     <= '0;
    end else if (step && !lock) begin
      prev_q <= code;
      code   <= target;
      dir_q  <= dir_nxt;
      if (reversal) rev_seen_q <= 1'b1;
    end
  end

endmodule

// File: rtl/mppt_hybrid_ctrl.sv
module mppt_hybrid_ctrl
  import mppt_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [LEN_W-1:0]  sample_len,
  input  logic              meas_valid,
  input  logic              meas_gt,
  output logic              meas_ready,
  input  logic              slow_tick,
  output logic [CODE_W-1:0] ladder_code,
  output logic              oc_point,
  output logic              sh_close,
  output logic              main_open,
  output logic              track_mode
);
  ctrl_state_e       state_q;
  logic [CODE_W-1:0] hold_code_q;

  logic              win_busy;
  logic              win_hold;
  logic              win_done;
  logic              tick_go;
  logic              accept;
  logic              srch_lock;
  logic [CODE_W-1:0] srch_code;
  logic [CODE_W-1:0] srch_lock_code;

  assign tick_go = (state_q == ST_TRACK) && slow_tick && !restart;
  assign accept  = meas_valid && meas_ready && !restart;

  mppt_window_timer #(.LEN_W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (restart || tick_go),
    .len     (sample_len),
    .busy    (win_busy),
    .hold_sw (win_hold),
    .done    (win_done)
  );

  mppt_po_search #(.CODE_W(CODE_W)) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (restart),
    .step      (accept),
    .gt        (meas_gt),
    .code      (srch_code),
    .lock      (srch_lock),
    .lock_code (srch_lock_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_OCV_SAMPLE;
      hold_code_q <= '0;
    end else if (restart) begin
      state_q <= ST_OCV_SAMPLE;
    end else begin
      unique case (state_q)
        ST_OCV_SAMPLE: if (win_done) state_q <= ST_SEARCH;
        ST_SEARCH: if (srch_lock) begin
          state_q     <= ST_TRACK;
          hold_code_q <= srch_lock_code;
        end
        ST_TRACK:    if (tick_go) state_q <= ST_RESAMPLE;
        ST_RESAMPLE: if (win_done) state_q <= ST_TRACK;
        default:     state_q <= ST_OCV_SAMPLE;
      endcase
    end
  end

  assign track_mode  = (state_q == ST_TRACK) || (state_q == ST_RESAMPLE);
  assign ladder_code = track_mode ? hold_code_q : srch_code;
  assign oc_point    = (state_q == ST_OCV_SAMPLE);
  assign meas_ready  = (state_q == ST_SEARCH);
  assign main_open   = win_busy;
  assign sh_close    = win_hold;

endmodule

// File: rtl/mppt_ctrl_checker.sv
module mppt_ctrl_checker #(
  parameter int CODE_W = 3,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              restart,
  input logic              meas_valid,
  input logic              meas_ready,
  input logic              slow_tick,
  input logic [CODE_W-1:0] ladder_code,
  input logic              oc_point,
  input logic              sh_close,
  input logic              main_open,
  input logic              track_mode
);

  assert_hold_inside_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_close |-> main_open);

  assert_ready_only_connected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_ready |-> (!main_open && !oc_point && !track_mode));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_ready && !restart) |=>
      (track_mode ||
       ({1'b0, ladder_code} == {1'b0, $past(ladder_code)} + (CODE_W+1)'(1)) ||
       ({1'b0, ladder_code} + (CODE_W+1)'(1) == {1'b0, $past(ladder_code)})));

  assert_fixed_code_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (track_mode && !restart) |=> (track_mode && $stable(ladder_code)));

  assert_window_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(main_open) |-> $past(slow_tick || restart));

  assert_code_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!track_mode && !restart && !(meas_valid && meas_ready)) |=> $stable(ladder_code));

endmodule

bind mppt_hybrid_ctrl mppt_ctrl_checker #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .restart     (restart),
  .meas_valid  (meas_valid),
  .meas_ready  (meas_ready),
  .slow_tick   (slow_tick),
  .ladder_code (ladder_code),
  .oc_point    (oc_point),
  .sh_close    (sh_close),
  .main_open   (main_open),
  .track_mode  (track_mode)
);

// File: tb/tb_mppt_hybrid_ctrl.sv
module tb_mppt_hybrid_ctrl;
  localparam int CODE_W = 3;
  localparam int LEN_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic [LEN_W-1:0] sample_len = 8'd4;
  logic meas_valid = 1'b0;
  logic meas_gt = 1'b0;
  logic slow_tick = 1'b0;
  logic meas_ready;
  logic [CODE_W-1:0] ladder_code;
  logic oc_point, sh_close, main_open, track_mode;

  always #4 clk = ~clk;

  mppt_hybrid_ctrl #(.CODE_W(CODE_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .sample_len(sample_len),
    .meas_valid(meas_valid), .meas_gt(meas_gt), .meas_ready(meas_ready),
    .slow_tick(slow_tick), .ladder_code(ladder_code), .oc_point(oc_point),
    .sh_close(sh_close), .main_open(main_open), .track_mode(track_mode)
  );

  int n_checks = 0;
  int n_fail = 0;

  // Reference model: 0 session sample, 1 search, 2 fixed, 3 resample.
  int m_phase = 0;
  int m_busy = 1, m_cnt = 0;
  int m_code = 0, m_dir = 1, m_rev = 0, m_prev = 0, m_hold = 0;

  function automatic int m_last();
    return ((sample_len == 0) ? 1 : int'(sample_len)) + 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_busy = 1; m_cnt = 0;
      m_code = 0; m_dir = 1; m_rev = 0; m_prev = 0; m_hold = 0;
    end else if (restart) begin
      m_phase = 0; m_busy = 1; m_cnt = 0;
      m_code = 0; m_dir = 1; m_rev = 0; m_prev = 0;
    end else begin
      bit fin, tick_ok;
      fin = (m_busy == 1) && (m_cnt == m_last());
      tick_ok = (m_phase == 2) && slow_tick;
      if (tick_ok) begin m_busy = 1; m_cnt = 0; end
      else if (fin) m_busy = 0;
      else if (m_busy == 1) m_cnt++;
      case (m_phase)
        0: if (fin) m_phase = 1;
        1: if (meas_valid) begin
          int nd, t;
          nd = meas_gt ? m_dir : 1 - m_dir;
          t = m_code + (nd == 1 ? 1 : -1);
          if (t < 0 || t > 7) begin
            nd = 1 - nd;
            t = m_code + (nd == 1 ? 1 : -1);
          end
          if (nd != m_dir && m_rev == 1) begin
            m_hold = meas_gt ? m_code : m_prev;
            m_phase = 2;
          end else begin
            if (nd != m_dir) m_rev = 1;
            m_prev = m_code; m_code = t; m_dir = nd;
          end
        end
        2: if (tick_ok) m_phase = 3;
        3: if (fin) m_phase = 2;
        default: m_phase = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  // Every falling edge compares all outputs with the model.
  always @(negedge clk) begin
    int e_code;
    e_code = (m_phase >= 2) ? m_hold : m_code;
    chk("R2", "main_open", int'(main_open), m_busy);
    chk("R2", "sh_close", int'(sh_close),
        (m_busy == 1 && m_cnt != 0 && m_cnt != m_last()) ? 1 : 0);
    chk("R3", "oc_point", int'(oc_point), (m_phase == 0) ? 1 : 0);
    chk("R4", "meas_ready", int'(meas_ready), (m_phase == 1) ? 1 : 0);
    chk("R8", "track_mode", int'(track_mode), (m_phase >= 2) ? 1 : 0);
    chk("R12", "ladder_code", int'(ladder_code), e_code);
  end

  function automatic int curve(input int peak, input int c);
    return 100 - 10 * ((c > peak) ? c - peak : peak - c);
  endfunction

  // R5 R6 R7: feed results from a single-peak power curve until the lock.
  task automatic do_search(input int peak);
    int prev_p;
    prev_p = 0;
    while (m_phase != 2) begin
      @(negedge clk);
      if (m_phase == 1) begin
        int p;
        p = curve(peak, m_code);
        meas_valid = 1'b1;
        meas_gt = (p > prev_p);
        prev_p = p;
        @(negedge clk);
        meas_valid = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    @(negedge clk);
    chk("R7", "kept code vs peak", int'(ladder_code), peak);
  endtask

  task automatic pulse_tick();
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
  endtask

  task automatic pulse_restart();
    restart = 1'b1; @(negedge clk); restart = 1'b0;
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1", "reset main_open", int'(main_open), 1);
    chk("R1", "reset oc_point", int'(oc_point), 1);
    rst_n = 1'b1;
    @(negedge clk);
    pulse_tick();                       // R10: ignored during session sample
    do_search(3);                       // R3 R5: climb then bracket
    repeat (4) @(negedge clk);
    chk("R8", "fixed code", int'(ladder_code), 3);
    pulse_tick();                       // R9: resample window
    @(negedge clk);
    pulse_tick();                       // R10: ignored inside resample window
    repeat (10) @(negedge clk);
    chk("R9", "code after resample", int'(ladder_code), 3);
    sample_len = 8'd0;                  // R2: zero length acts as one
    meas_valid = 1'b1; meas_gt = 1'b1;  // R4: held through the window
    pulse_restart();                    // R11
    while (m_phase != 1) @(negedge clk);
    @(negedge clk);
    meas_valid = 1'b0;
    do_search(7);                       // R6: bounce at top end
    pulse_tick();
    repeat (6) @(negedge clk);
    sample_len = 8'd2;
    pulse_restart();
    do_search(0);                       // R6: bounce at bottom end
    sample_len = 8'd3;
    pulse_restart();
    while (m_phase != 1) @(negedge clk);
    meas_valid = 1'b1; meas_gt = 1'b1;
    @(negedge clk);
    meas_valid = 1'b0;
    pulse_tick();                       // R10: ignored during search
    pulse_restart();                    // R11: restart mid-search
    chk("R11", "restart code", int'(ladder_code), 0);
    do_search(5);
    pulse_tick();
    repeat (8) @(negedge clk);
  endtask

  initial begin
    bit timeout;
    timeout = 1'b0;
    fork
      run_all();
      begin repeat (20000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired (R1..) actual=hung expected=finished");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule